// File: doc/BRIEF.md
# Programmable Memory and Peripheral Chip-Select Unit

This block turns each bus cycle into a set of active-low select strobes for the memories and peripherals attached to a 16-bit processor bus. It watches a 20-bit memory address or a 16-bit I/O address and compares it with ranges held in four software-written configuration registers. The four ranges are: a block pinned to the top of the 1 MB space, a block pinned to address zero, a mid-memory block split into four equal quarters, and a peripheral area cut into six 128-byte windows. The peripheral area can be placed in either address space.

The sixth peripheral output has a second use. It can instead carry a latched copy of address bit 1, which is captured at the start of each accepted bus cycle. Select outputs are registered at the clock edge where the address is presented, and they return high at the edge that ends the cycle. While the bus is held, no new cycle is accepted, so every output, including the latched address bit, keeps its value.

Top module: `chip_select_unit`

## Requirements
- R1: After reset every output is high. Only the top-of-memory select is enabled, at its 1 KB size, so a memory cycle at 0xFFC00–0xFFFFF asserts `upper_cs_n` and nothing else.
- R2: `upper_cs_n` asserts for an enabled memory cycle whose address is at least 2^20 − 2^(10+k), where k is the 4-bit size code. Codes above 8 are stored as 8, which gives 256 KB.
- R3: `lower_cs_n` asserts for an enabled memory cycle whose address is below 2^(10+k). Codes above 8 are stored as 8.
- R4: The mid block has size 2^(13+k), with codes above 6 stored as 6 (512 KB). Its base is the 7-bit field times 8 KB, with the base bits below the block size ignored. `mid_cs_n[i]` asserts when an enabled memory cycle falls in quarter i of the block.
- R5: The peripheral area starts at base field × 1 KB. `per_cs_n[i]` asserts for offsets 128·i to 128·i+127, for i = 0..4. Output 5 covers offsets 640–767 when it is in select mode. No window asserts at offset 768 or above. The space bit chooses I/O cycles, where only address bits 15:0 and base bits 5:0 are compared, or memory cycles. Cycles of the other type assert no peripheral select.
- R6: With the latched-A1 bit set, `per5_out` shows address bit 1 of the last accepted cycle start, keeps it after the cycle ends, and never acts as a select. With the bit clear, `per5_out` is the sixth window select.
- R7: While `hold` is high, `addr_valid` is ignored. Select outputs and the latched address bit stay unchanged, except that `cycle_end` still releases the selects.
- R8: Select outputs change only at a rising edge with `addr_valid` high (and `hold` low). All of them go high at a rising edge with `cycle_end` high and `addr_valid` low. A register write during a cycle does not alter the selects of that cycle.
- R9: When an address lies in several programmed regions, every matching select asserts. No region takes priority over another.
- R10: An I/O cycle (`bus_io` high) asserts none of the upper, lower or mid selects.
- R11: `wr_sel` chooses the register: 0 upper, 1 lower, 2 mid, 3 peripheral. Bit 15 is the enable. Bits 3:0 hold the size code for upper, lower and mid. Bits 12:6 hold the mid base. For the peripheral register, bit 14 is the space (1 = I/O), bit 13 is latched-A1 mode, and bits 9:0 are the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 20 | Cycle address (I/O cycles use bits 15:0) |
| bus_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| addr_valid | input | 1 | Address valid; starts a cycle at this edge |
| cycle_end | input | 1 | Ends the current cycle |
| hold | input | 1 | Bus held; no cycle may start |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select |
| wr_data | input | 16 | Register write data |
| upper_cs_n | output | 1 | Top-of-memory select, active low |
| lower_cs_n | output | 1 | Bottom-of-memory select, active low |
| mid_cs_n | output | 4 | Mid-block quarter selects, active low |
| per_cs_n | output | 5 | Peripheral window selects 0–4, active low |
| per5_out | output | 1 | Sixth peripheral select or latched address bit 1 |

## Verification
The hardest condition to reach is a latched address bit that must survive a bus hold. It only appears when latched-A1 mode is on, a cycle has already captured a known bit 1, and `addr_valid` is then pulsed during hold with the opposite bit. The bench sets up that exact sequence as a directed case. It also writes a register in the middle of an active cycle to show that the current selects do not change. Random cycles are steered towards the region edges, the quarter and window boundaries, and the aliased upper bits of I/O addresses. Interleaved random register writes keep the regions shifting and overlapping.

// File: rtl/csu_pkg.sv
// Shared constants and configuration types for the chip-select unit.
// Assumes a 20-bit memory space and a 16-bit I/O space.
package csu_pkg;
    localparam int ADDR_W      = 20;
    localparam int IO_W        = 16;
    localparam int DATA_W      = 16;
    localparam int CODE_W      = 4;
    localparam int SH_W        = 5;
    localparam int UL_MIN_SH   = 10;
    localparam int UL_MAX_CODE = 8;
    localparam int MID_MIN_SH  = 13;
    localparam int MID_MAX_CODE = 6;
    localparam int MID_PARTS   = 4;
    localparam int PART_W      = $clog2(MID_PARTS);
    localparam int PER_COUNT   = 6;
    localparam int PER_WIN_SH  = 7;
    localparam int PER_BASE_SH = 10;
    localparam int WIN_IDX_W   = PER_BASE_SH - PER_WIN_SH;
    localparam int MID_BASE_W  = ADDR_W - MID_MIN_SH;
    localparam int PER_BASE_W  = ADDR_W - PER_BASE_SH;
    localparam int IO_BASE_W   = IO_W - PER_BASE_SH;
    localparam int NUM_CS      = 2 + MID_PARTS + PER_COUNT;

    typedef enum logic [1:0] {
        SEL_UPPER = 2'd0,
        SEL_LOWER = 2'd1,
        SEL_MID   = 2'd2,
        SEL_PER   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              en;
        logic [CODE_W-1:0] code;
    } ul_cfg_t;

    typedef struct packed {
        logic                  en;
        logic [MID_BASE_W-1:0] base;
        logic [CODE_W-1:0]     code;
    } mid_cfg_t;

    typedef struct packed {
        logic                  en;
        logic                  io_space;
        logic                  a1_mode;
        logic [PER_BASE_W-1:0] base;
    } per_cfg_t;

    // Limit a size code to the largest legal value.
    function automatic logic [CODE_W-1:0] clamp_code(input logic [CODE_W-1:0] c,
                                                     input logic [CODE_W-1:0] lim);
        return (c > lim) ? lim : c;
    endfunction
endpackage

// File: rtl/csu_regs.sv
// Configuration register file of the chip-select unit.
// One write port. Size codes are clamped as they are stored.
// Assumes wr_data follows the field layout given in the brief.
module csu_regs
    import csu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output ul_cfg_t           upper_cfg,
    output ul_cfg_t           lower_cfg,
    output mid_cfg_t          mid_cfg,
    output per_cfg_t          per_cfg
);
    localparam int EN_BIT   = DATA_W - 1;
    localparam int IO_BIT   = DATA_W - 2;
    localparam int A1_BIT   = DATA_W - 3;
    localparam int MB_LSB   = 6;
    localparam logic [CODE_W-1:0] UL_LIM  = CODE_W'(UL_MAX_CODE);
    localparam logic [CODE_W-1:0] MID_LIM = CODE_W'(MID_MAX_CODE);

    // Reset to the upper-only default and store written fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_cfg.en   <= 1'b1;
            upper_cfg.code <= '0;
            lower_cfg      <= '0;
            mid_cfg        <= '0;
            per_cfg        <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_UPPER: begin
                    upper_cfg.en   <= wr_data[EN_BIT];
                    upper_cfg.code <= clamp_code(wr_data[CODE_W-1:0], UL_LIM);
                end
                SEL_LOWER: begin
                    lower_cfg.en   <= wr_data[EN_BIT];
                    lower_cfg.code <= clamp_code(wr_data[CODE_W-1:0], UL_LIM);
                end
                SEL_MID: begin
                    mid_cfg.en   <= wr_data[EN_BIT];
                    mid_cfg.base <= wr_data[MB_LSB+MID_BASE_W-1:MB_LSB];
                    mid_cfg.code <= clamp_code(wr_data[CODE_W-1:0], MID_LIM);
                end
                default: begin
                    per_cfg.en       <= wr_data[EN_BIT];
                    per_cfg.io_space <= wr_data[IO_BIT];
                    per_cfg.a1_mode  <= wr_data[A1_BIT];
                    per_cfg.base     <= wr_data[PER_BASE_W-1:0];
                end
            endcase
        end
    end
endmodule

// File: rtl/csu_decode.sv
// Combinational range decoder. Produces active-high hits for every select.
// Assumes the configuration is already clamped. Has no state.
module csu_decode
    import csu_pkg::*;
(
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 is_io,
    input  ul_cfg_t              upper_cfg,
    input  ul_cfg_t              lower_cfg,
    input  mid_cfg_t             mid_cfg,
    input  per_cfg_t             per_cfg,
    output logic [NUM_CS-1:0]    hits
);
    localparam logic [ADDR_W-1:0] IO_MASK = {{(ADDR_W-IO_W){1'b0}}, {IO_W{1'b1}}};

    // Ones below a bit position: the in-block offset mask.
    function automatic logic [ADDR_W-1:0] low_ones(input logic [SH_W-1:0] sh);
        return ({{(ADDR_W-1){1'b0}}, 1'b1} << sh) - {{(ADDR_W-1){1'b0}}, 1'b1};
    endfunction

    logic [SH_W-1:0]      up_sh, lo_sh, mid_sh;
    logic [ADDR_W-1:0]    up_mask, lo_mask, mid_mask, mid_base_full, part_shifted;
    logic [PART_W-1:0]    part;
    logic                 in_mid, mem_cyc;
    logic [ADDR_W-1:0]    per_addr, per_base_full;
    logic                 per_page, per_type_ok;
    logic [WIN_IDX_W-1:0] win;

    // Upper and lower region matches against power-of-two sizes.
    always_comb begin
        mem_cyc = !is_io;
        up_sh   = SH_W'(UL_MIN_SH) + SH_W'(upper_cfg.code);
        lo_sh   = SH_W'(UL_MIN_SH) + SH_W'(lower_cfg.code);
        up_mask = low_ones(up_sh);
        lo_mask = low_ones(lo_sh);
        hits[0] = upper_cfg.en && mem_cyc && ((addr | up_mask) == '1);
        hits[1] = lower_cfg.en && mem_cyc && ((addr & ~lo_mask) == '0);
    end

    // Mid block membership and the quarter it falls in.
    always_comb begin
        mid_sh        = SH_W'(MID_MIN_SH) + SH_W'(mid_cfg.code);
        mid_mask      = low_ones(mid_sh);
        mid_base_full = {mid_cfg.base, {MID_MIN_SH{1'b0}}};
        in_mid        = mid_cfg.en && mem_cyc && (((addr ^ mid_base_full) & ~mid_mask) == '0);
        part_shifted  = addr >> (mid_sh - SH_W'(PART_W));
        part          = part_shifted[PART_W-1:0];
    end

    for (genvar g = 0; g < MID_PARTS; g++) begin : g_mid
        assign hits[2+g] = in_mid && (part == PART_W'(g));
    end

    // Peripheral page match in the chosen address space.
    always_comb begin
        per_addr      = per_cfg.io_space ? (addr & IO_MASK) : addr;
        per_base_full = {per_cfg.base, {PER_BASE_SH{1'b0}}};
        if (per_cfg.io_space)
            per_base_full = per_base_full & IO_MASK;
        per_page    = per_addr[ADDR_W-1:PER_BASE_SH] == per_base_full[ADDR_W-1:PER_BASE_SH];
        per_type_ok = per_cfg.en && (per_cfg.io_space == is_io);
        win         = per_addr[PER_BASE_SH-1:PER_WIN_SH];
    end

    for (genvar p = 0; p < PER_COUNT; p++) begin : g_per
        if (p == PER_COUNT - 1) begin : g_last
            assign hits[2+MID_PARTS+p] = per_type_ok && per_page && !per_cfg.a1_mode
                                         && (win == WIN_IDX_W'(p));
        end else begin : g_plain
            assign hits[2+MID_PARTS+p] = per_type_ok && per_page && (win == WIN_IDX_W'(p));
        end
    end
endmodule

// File: rtl/csu_outreg.sv
// Output stage: captures select hits when a cycle starts, releases them when the cycle ends,
// and latches address bit 1. The top output bit is muxed between select and latched bit.
// Assumes start already excludes bus hold.
module csu_outreg
    import csu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cycle_end,
    input  logic              a1_in,
    input  logic              a1_mode,
    input  logic [NUM_CS-1:0] hits,
    output logic [NUM_CS-1:0] cs_n,
    output logic              a1_q
);
    logic [NUM_CS-1:0] cs_q;

    // Register the active-low selects for the length of the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cs_q <= '1;
        else if (start)
            cs_q <= ~hits;
        else if (cycle_end)
            cs_q <= '1;
    end

    // Capture address bit 1 at every accepted cycle start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            a1_q <= 1'b0;
        else if (start)
            a1_q <= a1_in;
    end

    // Route the last output to either its select or the latched bit.
    always_comb begin
        cs_n           = cs_q;
        cs_n[NUM_CS-1] = a1_mode ? a1_q : cs_q[NUM_CS-1];
    end
endmodule

// File: rtl/chip_select_unit.sv
// Top of the chip-select unit: register file, range decoder and output stage.
// Assumes addr_valid and cycle_end are single-clock strobes from the bus sequencer.
module chip_select_unit
    import csu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_io,
    input  logic                 addr_valid,
    input  logic                 cycle_end,
    input  logic                 hold,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [DATA_W-1:0]    wr_data,
    output logic                 upper_cs_n,
    output logic                 lower_cs_n,
    output logic [MID_PARTS-1:0] mid_cs_n,
    output logic [PER_COUNT-2:0] per_cs_n,
    output logic                 per5_out
);
    ul_cfg_t           upper_cfg, lower_cfg;
    mid_cfg_t          mid_cfg;
    per_cfg_t          per_cfg;
    logic [NUM_CS-1:0] hits, cs_n;
    logic              a1_latch;
    logic              start;

    assign start = addr_valid && !hold;

    csu_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .upper_cfg(upper_cfg), .lower_cfg(lower_cfg), .mid_cfg(mid_cfg), .per_cfg(per_cfg)
    );

    csu_decode u_decode (
        .addr(bus_addr), .is_io(bus_io), .upper_cfg(upper_cfg), .lower_cfg(lower_cfg),
        .mid_cfg(mid_cfg), .per_cfg(per_cfg), .hits(hits)
    );

    csu_outreg u_out (
        .clk(clk), .rst_n(rst_n), .start(start), .cycle_end(cycle_end), .a1_in(bus_addr[1]),
        .a1_mode(per_cfg.a1_mode), .hits(hits), .cs_n(cs_n), .a1_q(a1_latch)
    );

    assign upper_cs_n = cs_n[0];
    assign lower_cs_n = cs_n[1];
    assign mid_cs_n   = cs_n[2 +: MID_PARTS];
    assign per_cs_n   = cs_n[2+MID_PARTS +: PER_COUNT-1];
    assign per5_out   = cs_n[NUM_CS-1];
endmodule

// File: rtl/chip_select_unit_checker.sv
// Temporal checks on the chip-select unit, bound into the top module.
module chip_select_unit_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       addr_valid,
    input logic       cycle_end,
    input logic       hold,
    input logic       bus_io,
    input logic       wr_en,
    input logic [1:0] addr_top,
    input logic       upper_cs_n,
    input logic       lower_cs_n,
    input logic [3:0] mid_cs_n,
    input logic [4:0] per_cs_n,
    input logic       per5_out,
    input logic       a1_latch
);
    logic [11:0] all_out;
    assign all_out = {per5_out, per_cs_n, mid_cs_n, lower_cs_n, upper_cs_n};

    // R8: ending a cycle releases every select
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_end && !addr_valid) |=> (upper_cs_n && lower_cs_n && (&mid_cs_n) && (&per_cs_n)));

    // R8: no strobe and no write means no output movement
    a_r8_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_valid && !cycle_end && !wr_en) |=> $stable(all_out));

    // R7: hold blocks a new cycle even with addr_valid high
    a_r7_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !cycle_end && !wr_en) |=> $stable(all_out));

    // R7: latched address bit kept through hold
    a_r7_a1_kept: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(a1_latch));

    // R10: I/O cycles leave memory selects idle
    a_r10_io_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !hold && bus_io) |=> (upper_cs_n && lower_cs_n && (&mid_cs_n)));

    // R2: upper region never reaches below the top 256 KB
    a_r2_upper_top: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !hold && (addr_top != 2'b11)) |=> upper_cs_n);

    // R3: lower region never reaches above the bottom 256 KB
    a_r3_lower_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !hold && (addr_top != 2'b00)) |=> lower_cs_n);

    // R4: at most one quarter selected
    a_r4_one_quarter: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mid_cs_n));

    // R5: at most one peripheral window selected
    a_r5_one_window: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~per_cs_n));
endmodule

bind chip_select_unit chip_select_unit_checker u_chk (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .cycle_end(cycle_end), .hold(hold),
    .bus_io(bus_io), .wr_en(wr_en), .addr_top(bus_addr[19:18]), .upper_cs_n(upper_cs_n),
    .lower_cs_n(lower_cs_n), .mid_cs_n(mid_cs_n), .per_cs_n(per_cs_n), .per5_out(per5_out),
    .a1_latch(a1_latch)
);

// File: tb/chip_select_unit_bench.sv
module chip_select_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bus_addr = '0;
    logic        bus_io = 1'b0;
    logic        addr_valid = 1'b0;
    logic        cycle_end = 1'b0;
    logic        hold = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        upper_cs_n, lower_cs_n, per5_out;
    logic [3:0]  mid_cs_n;
    logic [4:0]  per_cs_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench-side copy of the programmed configuration (R11 layout)
    bit       u_en = 1; int u_code = 0;
    bit       l_en = 0; int l_code = 0;
    bit       m_en = 0; int m_code = 0; int m_base = 0;
    bit       p_en = 0; bit p_io = 0; bit p_a1 = 0; int p_base = 0;
    bit       a1_exp = 0;

    always #10 clk = ~clk;

    chip_select_unit u_chip_select_unit (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_io(bus_io),
        .addr_valid(addr_valid), .cycle_end(cycle_end), .hold(hold), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .upper_cs_n(upper_cs_n), .lower_cs_n(lower_cs_n),
        .mid_cs_n(mid_cs_n), .per_cs_n(per_cs_n), .per5_out(per5_out)
    );

    function automatic logic [11:0] expv(input logic [19:0] a, input bit io);
        logic [11:0] h;
        logic [11:0] e;
        int ia, size, start, pa, pb;
        h = '0;
        ia = int'(a);
        if (u_en && !io && ia >= (1 << 20) - (1 << (10 + u_code))) h[0] = 1'b1;
        if (l_en && !io && ia < (1 << (10 + l_code))) h[1] = 1'b1;
        size  = 1 << (13 + m_code);
        start = (m_base << 13) & ~(size - 1);
        if (m_en && !io && ia >= start && ia < start + size) h[2 + (ia - start) / (size / 4)] = 1'b1;
        pa = p_io ? (ia & 32'hFFFF) : ia;
        pb = p_io ? ((p_base << 10) & 32'hFFFF) : (p_base << 10);
        if (p_en && (p_io == io) && pa >= pb && pa - pb < 768) h[6 + (pa - pb) / 128] = 1'b1;
        e = ~h;
        if (p_a1) e[11] = a1_exp;
        return e;
    endfunction

    function automatic logic [11:0] idle_v();
        return {p_a1 ? a1_exp : 1'b1, 11'h7FF};
    endfunction

    task automatic check(input logic [11:0] exp, input string req);
        logic [11:0] got;
        got = {per5_out, per_cs_n, mid_cs_n, lower_cs_n, upper_cs_n};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: outputs %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (sel)
            2'd0: begin u_en = d[15]; u_code = (d[3:0] > 8) ? 8 : int'(d[3:0]); end
            2'd1: begin l_en = d[15]; l_code = (d[3:0] > 8) ? 8 : int'(d[3:0]); end
            2'd2: begin m_en = d[15]; m_code = (d[3:0] > 6) ? 6 : int'(d[3:0]);
                        m_base = int'(d[12:6]); end
            default: begin p_en = d[15]; p_io = d[14]; p_a1 = d[13]; p_base = int'(d[9:0]); end
        endcase
    endtask

    // One full bus cycle: start, check selects, end, check release
    task automatic cyc(input logic [19:0] a, input bit io, input string req);
        @(negedge clk);
        addr_valid = 1'b1; bus_addr = a; bus_io = io;
        @(negedge clk);
        addr_valid = 1'b0;
        a1_exp = a[1];
        check(expv(a, io), req);
        cycle_end = 1'b1;
        @(negedge clk);
        cycle_end = 1'b0;
        check(idle_v(), "R8 release");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: outputs %h expected cycle completion", {per5_out, per_cs_n});
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [19:0] ra;
        bit          rio;
        void'($urandom(32'd5417));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(12'hFFF, "R1 reset idle");
        cyc(20'hFFFFF, 0, "R1 upper default");
        cyc(20'hFFC00, 0, "R1 upper low edge");
        cyc(20'hFFBFF, 0, "R2 below 1K");
        cyc(20'hFFFFF, 1, "R10 io at top");

        wr(2'd0, 16'h800F);                     // R2 clamp to 256K
        cyc(20'hC0000, 0, "R2 clamped edge in");
        cyc(20'hBFFFF, 0, "R2 clamped edge out");
        wr(2'd1, 16'h8002);                     // R3 4K
        cyc(20'h00FFF, 0, "R3 last byte");
        cyc(20'h01000, 0, "R3 past end");
        wr(2'd1, 16'h800C);
        cyc(20'h3FFFF, 0, "R3 clamped 256K");
        wr(2'd1, 16'h0000);

        wr(2'd2, 16'h8000 | (16'h20 << 6) | 16'h1);   // R4 16K at 0x40000
        cyc(20'h40000, 0, "R4 quarter 0");
        cyc(20'h41000, 0, "R4 quarter 1");
        cyc(20'h43FFF, 0, "R4 quarter 3");
        cyc(20'h44000, 0, "R4 past block");
        cyc(20'h3FFFF, 0, "R4 before block");
        wr(2'd2, 16'h8000 | (16'h21 << 6) | 16'h1);   // unaligned base masked
        cyc(20'h42000, 0, "R4 aligned base");
        cyc(20'h41000, 1, "R10 io in mid");

        wr(2'd3, 16'h8002);                     // R5 memory at 0x800
        cyc(20'h00800, 0, "R5 window 0");
        cyc(20'h0087F, 0, "R5 window 0 end");
        cyc(20'h00880, 0, "R5 window 1");
        cyc(20'h00A80, 0, "R5 window 5");
        cyc(20'h00B00, 0, "R5 past area");
        cyc(20'h00800, 1, "R5 wrong space");
        wr(2'd3, 16'hC003);                     // R5 I/O at 0xC00
        cyc(20'hF0C80, 1, "R5 io alias");
        cyc(20'h00C80, 0, "R5 mem ignored");

        wr(2'd3, 16'hE003);                     // R6 latched A1
        cyc(20'h00E82, 1, "R6 a1 one");
        cyc(20'h00E80, 1, "R6 a1 zero");
        cyc(20'h00E86, 1, "R6 a1 one again");

        // R7: hold with a start whose bit 1 is opposite
        @(negedge clk);
        hold = 1'b1; addr_valid = 1'b1; bus_addr = 20'hFFFFD; bus_io = 1'b0;
        @(negedge clk);
        addr_valid = 1'b0;
        check(idle_v(), "R7 start ignored in hold");
        @(negedge clk);
        check(idle_v(), "R7 a1 kept in hold");
        hold = 1'b0;

        // R8: write during an active cycle
        @(negedge clk);
        addr_valid = 1'b1; bus_addr = 20'hFFFF0; bus_io = 1'b0;
        @(negedge clk);
        addr_valid = 1'b0;
        a1_exp = 1'b0;
        check(expv(20'hFFFF0, 0), "R8 cycle before write");
        begin
            logic [11:0] held;
            held = expv(20'hFFFF0, 0);
            wr(2'd0, 16'h0000);
            check(held, "R8 write mid-cycle");
        end
        cycle_end = 1'b1;
        @(negedge clk);
        cycle_end = 1'b0;
        check(idle_v(), "R8 release after write");
        cyc(20'hFFFF0, 0, "R8 new config applies");

        // R9: overlapping regions
        wr(2'd1, 16'h8008);
        wr(2'd2, 16'h8000);
        wr(2'd0, 16'h8008);
        cyc(20'h00000, 0, "R9 lower and mid");
        wr(2'd2, 16'h8000 | (16'h60 << 6));
        cyc(20'hC1000, 0, "R9 upper and mid");

        // Random cycles and writes
        for (int i = 0; i < 600; i++) begin
            if ($urandom % 8 == 0) begin
                wr(2'($urandom % 4), 16'($urandom));
            end else begin
                case ($urandom % 5)
                    0: ra = 20'($urandom);
                    1: ra = 20'hFFFFF - 20'($urandom % 300000);
                    2: ra = 20'($urandom % 300000);
                    3: ra = 20'((m_base << 13) + ($urandom % (1 << (14 + m_code))));
                    default: ra = 20'((p_base << 10) + ($urandom % 1024)) ^ (20'($urandom % 16) << 16);
                endcase
                rio = ($urandom % 4 == 0);
                cyc(ra, rio, "R2 R3 R4 R5 R6 R9 R10 random");
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule